// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a cycle counter with a compare register. It is meant to be built once each for a processor tick timer, a system tick timer and a hypervisor system tick timer. The counter value is 63 bits wide. It advances by one on every cycle where a single-cycle rate strobe is high, so one fast clock can serve a slower nominal tick rate. The counter stops at its all-ones value and does not wrap. Software loads the counter and the compare register over a 64-bit write bus and reads both back on dedicated read ports.

The most significant bit of each 64-bit register word is a control flag and is not part of the value. In the counter word it marks that reads from unprivileged code should trap. The block stores this flag and returns it on read, and the privilege check itself lies outside the block. In the compare word the flag disables the interrupt.

Each write of the compare register arms a single match. When the counter equals the compare value while the match is armed, a sticky soft-interrupt bit is set. A compare value of zero, or a set disable flag, leaves the match disarmed. A parameter chooses which of two soft-interrupt lines the instance drives: the tick-match line or the system-tick-match line. The bit stays set until software pulses a clear strobe.

Top module: `tick_compare_timer`

## Requirements
- R1: A synchronous reset clears the counter, its trap flag, the compare value, the disable flag and the soft-interrupt output. It also cancels any armed match, so a count that later reaches the old compare value raises nothing.
- R2: A counter write loads wdata[62:0] as the count and wdata[63] as the trap flag. In the same cycle it takes precedence over the rate strobe.
- R3: The counter read port returns the trap flag in bit 63 and the 63-bit count in bits 62:0.
- R4: The count rises by exactly one on each cycle with the rate strobe high and no counter write. It holds its value on all other cycles.
- R5: The count saturates at 0x7FFF_FFFF_FFFF_FFFF and stays there under further rate strobes.
- R6: A compare write loads wdata[62:0] as the compare value and wdata[63] as the disable flag. The compare read port returns {disable flag, compare value}.
- R7: When an armed match sees the count equal to the compare value in a cycle, the selected soft-interrupt bit is high from the next clock edge onward.
- R8: A match fires at most once per compare write. After it fires, the count equalling the compare value again raises nothing until the compare register is written again, and that write re-arms the match.
- R9: A compare write with wdata[63] = 1 or with wdata[62:0] = 0 leaves the match disarmed, so no interrupt is raised.
- R10: The soft-interrupt bit stays high until a cycle with the clear strobe high. If a clear and a match fall in the same cycle, the bit stays high.
- R11: With parameter IRQ_SEL = SI_TICK the block drives soft_irq[0]. With IRQ_SEL = SI_STICK it drives soft_irq[1]. The other bit is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle rate strobe that advances the count |
| cnt_wr | input | 1 | Counter write strobe |
| lim_wr | input | 1 | Compare register write strobe |
| wdata | input | 64 | Write data for either register; bit 63 is the register's flag |
| irq_clr | input | 1 | Clears the soft-interrupt bit |
| cnt_rdata | output | 64 | {trap flag, count} |
| lim_rdata | output | 64 | {disable flag, compare value} |
| soft_irq | output | 2 | Soft-interrupt lines: bit 0 tick match, bit 1 system-tick match |

## Verification
The match is driven from several directions. In one case the count climbs into the compare value through rate strobes. In another a direct counter write lands on a value already matched, which separates the single-shot arming from a plain equality test. A disabled compare value and a zero compare value must stay silent, and a re-armed match that coincides with a clear shows whether setting wins over clearing. Two instances with different line selections receive the same stimulus, which separates the selected line from the idle one. Writes that carry bit 63, together with counts near the all-ones ceiling, show the flag split and the saturation.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // number of soft-interrupt lines a timer instance may drive
  localparam int SI_W = 2;

  // which soft-interrupt line an instance drives
  typedef enum logic [0:0] {
    SI_TICK  = 1'b0,
    SI_STICK = 1'b1
  } si_sel_e;
endpackage

// File: rtl/tick_count_reg.sv
module tick_count_reg #(
  parameter int VAL_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr,
  input  logic [VAL_W:0]   wdata,
  output logic [VAL_W-1:0] val_o,
  output logic             flag_o
);
  localparam logic [VAL_W-1:0] MAX_VAL = '1;

  logic [VAL_W-1:0] val_q;
  logic             flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      flag_q <= 1'b0;
    end else if (wr) begin
      val_q  <= wdata[VAL_W-1:0];
      flag_q <= wdata[VAL_W];
    end else if (tick_en && (val_q != MAX_VAL)) begin
      val_q  <= val_q + 1'b1;
    end
  end

  assign val_o  = val_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tick_limit_cmp.sv
module tick_limit_cmp #(
  parameter int VAL_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [VAL_W:0]   wdata,
  input  logic [VAL_W-1:0] cnt_val,
  output logic [VAL_W-1:0] lim_o,
  output logic             dis_o,
  output logic             hit_o
);
  logic [VAL_W-1:0] lim_q;
  logic             dis_q;
  logic             armed_q;
  logic             arm_ok;

  // a write arms the match only with a non-zero value and no disable flag
  assign arm_ok = (|wdata[VAL_W-1:0]) && !wdata[VAL_W];
  assign hit_o  = armed_q && (cnt_val == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q   <= '0;
      dis_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr) begin
      lim_q   <= wdata[VAL_W-1:0];
      dis_q   <= wdata[VAL_W];
      armed_q <= arm_ok;
    end else if (hit_o) begin
      armed_q <= 1'b0;
    end
  end

  assign lim_o = lim_q;
  assign dis_o = dis_q;
endmodule

// File: rtl/tick_softint_latch.sv
module tick_softint_latch #(
  parameter int SI_W = 2,
  parameter int SEL  = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit,
  input  logic            clr,
  output logic [SI_W-1:0] soft_irq
);
  for (genvar g = 0; g < SI_W; g++) begin : g_line
    if (g == SEL) begin : g_drv
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= hit | (bit_q & ~clr);
      end
      assign soft_irq[g] = bit_q;
    end else begin : g_idle
      assign soft_irq[g] = 1'b0;
    end
  end
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int               VAL_W   = 63,
  parameter tick_pkg::si_sel_e IRQ_SEL = tick_pkg::SI_TICK
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_en,
  input  logic                      cnt_wr,
  input  logic                      lim_wr,
  input  logic [VAL_W:0]            wdata,
  input  logic                      irq_clr,
  output logic [VAL_W:0]            cnt_rdata,
  output logic [VAL_W:0]            lim_rdata,
  output logic [tick_pkg::SI_W-1:0] soft_irq
);
  localparam int SEL_IDX = int'(IRQ_SEL);

  logic [VAL_W-1:0] cnt_val;
  logic             cnt_flag;
  logic [VAL_W-1:0] lim_val;
  logic             lim_dis;
  logic             hit;

  tick_count_reg #(.VAL_W(VAL_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr      (cnt_wr),
    .wdata   (wdata),
    .val_o   (cnt_val),
    .flag_o  (cnt_flag)
  );

  tick_limit_cmp #(.VAL_W(VAL_W)) u_lim (
    .clk     (clk),
    .rst     (rst),
    .wr      (lim_wr),
    .wdata   (wdata),
    .cnt_val (cnt_val),
    .lim_o   (lim_val),
    .dis_o   (lim_dis),
    .hit_o   (hit)
  );

  tick_softint_latch #(.SI_W(tick_pkg::SI_W), .SEL(SEL_IDX)) u_si (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .clr      (irq_clr),
    .soft_irq (soft_irq)
  );

  assign cnt_rdata = {cnt_flag, cnt_val};
  assign lim_rdata = {lim_dis, lim_val};
endmodule

// File: rtl/tick_compare_timer_chk.sv
module tick_compare_timer_chk #(
  parameter int VAL_W = 63,
  parameter int SEL   = 0
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      tick_en,
  input logic                      cnt_wr,
  input logic                      lim_wr,
  input logic [VAL_W:0]            wdata,
  input logic                      irq_clr,
  input logic [VAL_W:0]            cnt_rdata,
  input logic [VAL_W:0]            lim_rdata,
  input logic [tick_pkg::SI_W-1:0] soft_irq
);
  localparam logic [VAL_W-1:0] MAX_VAL = '1;
  localparam int OTHER = (SEL == 0) ? 1 : 0;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (cnt_rdata == '0 && lim_rdata == '0 && soft_irq == '0));

  // R4
  count_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !tick_en) |=> $stable(cnt_rdata));

  // R5
  count_saturates_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_rdata[VAL_W-1:0] == MAX_VAL && !cnt_wr) |=> (cnt_rdata[VAL_W-1:0] == MAX_VAL));

  // R6
  limit_load_chk: assert property (@(posedge clk) disable iff (rst)
    lim_wr |=> (lim_rdata == $past(wdata)));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (soft_irq[SEL] && !irq_clr) |=> soft_irq[SEL]);

  // R11
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    soft_irq[OTHER] == 1'b0);
endmodule

bind tick_compare_timer tick_compare_timer_chk #(.VAL_W(VAL_W), .SEL(SEL_IDX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .cnt_wr    (cnt_wr),
  .lim_wr    (lim_wr),
  .wdata     (wdata),
  .irq_clr   (irq_clr),
  .cnt_rdata (cnt_rdata),
  .lim_rdata (lim_rdata),
  .soft_irq  (soft_irq)
);

// File: tb/tick_compare_timer_test.sv
module tick_compare_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        cnt_wr = 1'b0;
  logic        lim_wr = 1'b0;
  logic [63:0] wdata = '0;
  logic        irq_clr = 1'b0;
  logic [63:0] cnt_rdata, lim_rdata, cnt_rdata_s, lim_rdata_s;
  logic [1:0]  soft_irq, soft_irq_s;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_compare_timer #(.VAL_W(63), .IRQ_SEL(tick_pkg::SI_TICK)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_wr(cnt_wr), .lim_wr(lim_wr),
    .wdata(wdata), .irq_clr(irq_clr), .cnt_rdata(cnt_rdata),
    .lim_rdata(lim_rdata), .soft_irq(soft_irq)
  );

  tick_compare_timer #(.VAL_W(63), .IRQ_SEL(tick_pkg::SI_STICK)) uut_sys (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_wr(cnt_wr), .lim_wr(lim_wr),
    .wdata(wdata), .irq_clr(irq_clr), .cnt_rdata(cnt_rdata_s),
    .lim_rdata(lim_rdata_s), .soft_irq(soft_irq_s)
  );

  typedef struct packed {
    logic        cw;
    logic        lw;
    logic        te;
    logic        clr;
    logic [63:0] wd;
    logic [63:0] exp_cnt;
    logic        exp_irq;
  } vec_t;

  // one row per cycle: inputs applied, then outputs after the edge
  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 64'd10, 64'd10, 1'b0},                  // R2 load count
    '{1'b0, 1'b1, 1'b0, 1'b0, 64'd12, 64'd10, 1'b0},                  // R6 arm at 12
    '{1'b0, 1'b0, 1'b1, 1'b0, 64'd0,  64'd11, 1'b0},                  // R4
    '{1'b0, 1'b0, 1'b1, 1'b0, 64'd0,  64'd12, 1'b0},                  // R4 reaches limit
    '{1'b0, 1'b0, 1'b0, 1'b0, 64'd0,  64'd12, 1'b1},                  // R7 fires
    '{1'b0, 1'b0, 1'b0, 1'b1, 64'd0,  64'd12, 1'b0},                  // R10 clear
    '{1'b1, 1'b0, 1'b0, 1'b0, 64'd11, 64'd11, 1'b0},                  // R2 rewind
    '{1'b0, 1'b0, 1'b1, 1'b0, 64'd0,  64'd12, 1'b0},                  // R8
    '{1'b0, 1'b0, 1'b0, 1'b0, 64'd0,  64'd12, 1'b0},                  // R8 no second fire
    '{1'b0, 1'b1, 1'b0, 1'b0, 64'h8000_0000_0000_000D, 64'd12, 1'b0}, // R9 disabled
    '{1'b0, 1'b0, 1'b1, 1'b0, 64'd0,  64'd13, 1'b0},                  // R4
    '{1'b0, 1'b0, 1'b0, 1'b0, 64'd0,  64'd13, 1'b0}                   // R9 silent
  };

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // both instances: tick line on bit 0, system line on bit 1 (R11)
  task automatic check_irq(input string tag, input logic exp);
    check64({tag, " R11 tick-line"}, {62'd0, soft_irq}, {62'd0, 1'b0, exp});
    check64({tag, " R11 sys-line"}, {62'd0, soft_irq_s}, {62'd0, exp, 1'b0});
  endtask

  task automatic step(input logic cw, input logic lw, input logic te,
                      input logic clr, input logic [63:0] wd);
    cnt_wr = cw; lim_wr = lw; tick_en = te; irq_clr = clr; wdata = wd;
    @(posedge clk); #1;
    cnt_wr = 1'b0; lim_wr = 1'b0; tick_en = 1'b0; irq_clr = 1'b0; wdata = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check64("R1 count after reset", cnt_rdata, 64'd0);
    check64("R1 limit after reset", lim_rdata, 64'd0);
    check_irq("R1 irq after reset", 1'b0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i].cw, VEC[i].lw, VEC[i].te, VEC[i].clr, VEC[i].wd);
      check64($sformatf("R4/R7 row %0d count", i), cnt_rdata, VEC[i].exp_cnt);
      check_irq($sformatf("R7/R8/R9 row %0d", i), VEC[i].exp_irq);
    end

    // R6 readback with flag
    step(1'b0, 1'b1, 1'b0, 1'b0, 64'h8000_0000_0000_0123);
    check64("R6 limit readback", lim_rdata, 64'h8000_0000_0000_0123);

    // R9 zero limit with count equal to zero
    step(1'b0, 1'b1, 1'b0, 1'b0, 64'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 64'd0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
    check_irq("R9 zero limit", 1'b0);

    // R2/R3 flag split, write beats tick
    step(1'b1, 1'b0, 1'b1, 1'b0, 64'h8000_0000_0000_0005);
    check64("R2 R3 write with flag", cnt_rdata, 64'h8000_0000_0000_0005);
    step(1'b0, 1'b0, 1'b1, 1'b0, 64'd0);
    check64("R3 R4 flag kept on tick", cnt_rdata, 64'h8000_0000_0000_0006);

    // R5 saturation
    step(1'b1, 1'b0, 1'b0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFE);
    step(1'b0, 1'b0, 1'b1, 1'b0, 64'd0);
    check64("R5 reach max", cnt_rdata, 64'h7FFF_FFFF_FFFF_FFFF);
    step(1'b0, 1'b0, 1'b1, 1'b0, 64'd0);
    check64("R5 stays at max", cnt_rdata, 64'h7FFF_FFFF_FFFF_FFFF);

    // R10 clear coinciding with a re-armed match
    step(1'b1, 1'b0, 1'b0, 1'b0, 64'd30);
    step(1'b0, 1'b1, 1'b0, 1'b0, 64'd30);
    step(1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
    check_irq("R7 match on written count", 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 64'd30);
    check_irq("R8 R10 held over rewrite", 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 64'd0);
    check_irq("R10 clear with match", 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 64'd0);
    check_irq("R10 clear alone", 1'b0);

    // R1 reset cancels an armed match
    step(1'b1, 1'b0, 1'b0, 1'b0, 64'd49);
    step(1'b0, 1'b1, 1'b0, 1'b0, 64'd50);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    check64("R1 count after mid reset", cnt_rdata, 64'd0);
    check64("R1 limit after mid reset", lim_rdata, 64'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 64'd49);
    step(1'b0, 1'b0, 1'b1, 1'b0, 64'd0);
    check64("R1 count reaches old limit", cnt_rdata, 64'd50);
    step(1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
    check_irq("R1 match cancelled", 1'b0);

    finish_run();
  end
endmodule